// File: doc/BRIEF.md
# Hardware-Paced Parallel Port Byte Transmitter

This block drains a queue of host data words to a printer-style peripheral with no software involvement per byte. The host, or a DMA engine answering the block's request line, writes whole words of one, two or four bytes into a small FIFO. The block splits the word at the head of the FIFO into bytes and sends each byte with the classic compatibility handshake: the byte is placed on the data pins, a low strobe pulse follows, and the next byte waits until the peripheral drops its Busy line.

The block works only while the port's three-bit mode input selects the FIFO mode, code 010. In any other mode it ignores writes, keeps its request low, empties its FIFO and leaves the strobe high. Software considers a forward transfer finished only when the FIFO is empty and Busy is low, and a single status output reports exactly that pair of conditions.

Top module: `pfifo_tx`

## Requirements
- R1: While `mode` is not 3'b010 a write has no effect: the FIFO stays empty, `pio_nstrobe` stays high and `dma_req` is low.
- R2: In mode 3'b010 each write with `wr_en` high stores one whole word of `PWORD_BYTES` bytes. `fifo_empty` is high when no word is held, and `fifo_full` is high when `DEPTH` words are held.
- R3: A write while `fifo_full` is high is dropped and sets `overflow`. `overflow` then stays high until reset, across mode changes.
- R4: The bytes of a word leave least significant first: byte k is `wr_data[8k+7:8k]`. A word is removed from the FIFO when the strobe of its last byte ends.
- R5: A byte appears on `pio_data` one clock before `pio_nstrobe` falls and stays unchanged until the next byte is loaded.
- R6: `pio_nstrobe` stays low for `strobe_len` clocks. A value of 0 is treated as 1.
- R7: A byte is started only when `busy_in` is sampled low. After a strobe pulse the block waits for `busy_in` low, and then uses one idle clock before the next byte is loaded.
- R8: `dma_req` is high exactly when the mode is 3'b010 and `fifo_full` is low.
- R9: `xfer_done` is high exactly when `fifo_empty` is high and `busy_in` is low.
- R10: A clock edge sampled with `mode` not 3'b010 discards all stored words and any partly sent word, and forces the handshake idle with `pio_nstrobe` high from the next cycle.
- R11: After reset `pio_nstrobe` is high, `pio_data` is 0, the FIFO is empty and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Port mode. 3'b010 enables the FIFO transmitter |
| wr_en | input | 1 | Write strobe for one whole word |
| wr_data | input | 8*PWORD_BYTES | Word to queue, byte 0 in the low bits |
| strobe_len | input | SLW | Strobe low time in clocks, 0 read as 1 |
| busy_in | input | 1 | Peripheral Busy line |
| dma_req | output | 1 | Request for more data |
| fifo_empty | output | 1 | No word held |
| fifo_full | output | 1 | DEPTH words held |
| overflow | output | 1 | Sticky flag for a dropped write |
| xfer_done | output | 1 | FIFO empty and Busy low |
| pio_data | output | 8 | Parallel data pins |
| pio_nstrobe | output | 1 | Active-low data strobe |

## Verification
The bench builds the block with two-byte words, a four-entry FIFO and a four-bit strobe length. The two-byte words exercise the byte index and the moment a word is removed mid-word. The shallow FIFO lets a held-high Busy fill the queue in a few writes, so full, the dropped write and the lowered request all occur. Strobe lengths of 0, 1 and 4 cover the zero-as-one rule, and a mode change during a live strobe exercises the flush.

// File: rtl/pfifo_tx.sv
module pfifo_tx #(
  parameter int PWORD_BYTES = 2,
  parameter int DEPTH       = 8,
  parameter int SLW         = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               mode,
  input  logic                     wr_en,
  input  logic [8*PWORD_BYTES-1:0] wr_data,
  input  logic [SLW-1:0]           strobe_len,
  input  logic                     busy_in,
  output logic                     dma_req,
  output logic                     fifo_empty,
  output logic                     fifo_full,
  output logic                     overflow,
  output logic                     xfer_done,
  output logic [7:0]               pio_data,
  output logic                     pio_nstrobe
);
  localparam int PW = 8 * PWORD_BYTES;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (PWORD_BYTES > 1) ? $clog2(PWORD_BYTES) : 1;
  localparam logic [2:0] FIFO_MODE = 3'b010;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STB, S_WAIT} st_t;

  st_t             st;
  logic [PW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;
  logic [IW-1:0]   idx;
  logic [SLW-1:0]  scnt;
  logic [7:0]      data_q;
  logic            ovf_q;

  logic active, do_wr, last_byte, do_pop;
  logic [PW-1:0] head_word;
  logic [7:0]    head_byte;

  assign active     = (mode == FIFO_MODE);
  assign fifo_empty = (count == '0);
  assign fifo_full  = (count == CW'(DEPTH));
  assign dma_req    = active && !fifo_full;
  assign xfer_done  = fifo_empty && !busy_in;
  assign overflow   = ovf_q;
  assign pio_data   = data_q;
  assign pio_nstrobe = (st != S_STB);

  assign do_wr      = active && wr_en && !fifo_full;
  assign last_byte  = (idx == IW'(PWORD_BYTES - 1));
  assign do_pop     = active && (st == S_STB) && (scnt == '0) && last_byte;
  assign head_word  = mem[rptr];
  assign head_byte  = 8'(head_word >> {idx, 3'b000});

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wptr   <= '0;
      rptr   <= '0;
      count  <= '0;
      idx    <= '0;
      scnt   <= '0;
      data_q <= '0;
      ovf_q  <= 1'b0;
    end else if (!active) begin
      st    <= S_IDLE;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      idx   <= '0;
    end else begin
      if (wr_en && fifo_full) ovf_q <= 1'b1;
      unique case (st)
        S_IDLE:
          if (!fifo_empty && !busy_in) begin
            data_q <= head_byte;
            st     <= S_SETUP;
          end
        S_SETUP: begin
          scnt <= (strobe_len == '0) ? '0 : strobe_len - 1'b1;
          st   <= S_STB;
        end
        S_STB:
          if (scnt == '0) begin
            st <= S_WAIT;
            if (last_byte) begin
              idx  <= '0;
              rptr <= ptr_inc(rptr);
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            scnt <= scnt - 1'b1;
          end
        S_WAIT:
          if (!busy_in) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (do_wr) wptr <= ptr_inc(wptr);
      case ({do_wr, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_data_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pio_nstrobe) |-> $stable(pio_data));

  a_r5_data_held_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !pio_nstrobe |-> $stable(pio_data));

  a_r7_start_needs_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pio_nstrobe) |-> !$past(busy_in, 2));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en && fifo_full) |=> overflow);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_req_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (!fifo_full && active));

  a_r10_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pio_nstrobe && fifo_empty));

  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));
endmodule

// File: tb/pfifo_tx_test.sv
module pfifo_tx_test;
  localparam int CLK_NS = 10;
  localparam int PB = 2;
  localparam int DEP = 4;
  localparam int SW = 4;
  localparam int PW = 8 * PB;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 3'b000;
  logic wr_en = 0;
  logic [PW-1:0] wr_data = '0;
  logic [SW-1:0] strobe_len = 4'd4;
  logic busy_in;
  logic dma_req, fifo_empty, fifo_full, overflow, xfer_done, pio_nstrobe;
  logic [7:0] pio_data;

  always #(CLK_NS/2) clk = ~clk;

  pfifo_tx #(.PWORD_BYTES(PB), .DEPTH(DEP), .SLW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .strobe_len(strobe_len), .busy_in(busy_in), .dma_req(dma_req),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow),
    .xfer_done(xfer_done), .pio_data(pio_data), .pio_nstrobe(pio_nstrobe));

  int nchk = 0, nerr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // peripheral: Busy after each strobe, captures data on strobe release
  bit stuck = 0;
  int hold = 3;
  logic pbusy = 0;
  int bcnt = 0;
  int nfalls = 0;
  logic prev_ns = 1;
  logic [7:0] got[$];
  assign busy_in = stuck | pbusy;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!pio_nstrobe && prev_ns) begin
        nfalls++;
        bcnt = hold;
        pbusy = (hold > 0);
      end else if (pio_nstrobe && !prev_ns) begin
        got.push_back(pio_data);
      end
      if (pio_nstrobe && bcnt > 0) begin
        bcnt--;
        if (bcnt == 0) pbusy = 0;
      end
      prev_ns = pio_nstrobe;
    end
  end

  // behavioural reference, advanced on each clock edge
  logic [PW-1:0] q[$];
  int m_st = 0, m_i = 0, m_c = 0, m_n;
  logic [7:0] m_pd = 0;
  bit m_ovf = 0;
  bit m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_st = 0; m_i = 0; m_c = 0; m_pd = 0; m_ovf = 0;
    end else if (mode != 3'b010) begin
      q.delete(); m_st = 0; m_i = 0;
    end else begin
      m_n = q.size();
      m_acc = wr_en && (m_n < DEP);
      if (wr_en && m_n == DEP) m_ovf = 1;
      case (m_st)
        0: if (m_n > 0 && !busy_in) begin m_pd = q[0][8*m_i +: 8]; m_st = 1; end
        1: begin m_st = 2; m_c = (strobe_len == 0) ? 1 : int'(strobe_len); end
        2: begin
          m_c--;
          if (m_c == 0) begin
            m_st = 3;
            if (m_i == PB - 1) begin void'(q.pop_front()); m_i = 0; end
            else m_i++;
          end
        end
        default: if (!busy_in) m_st = 0;
      endcase
      if (m_acc) q.push_back(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 nstrobe", pio_nstrobe, m_st != 2);
      chk("R5 data", pio_data, m_pd);
      chk("R2 empty", fifo_empty, q.size() == 0);
      chk("R2 full", fifo_full, q.size() == DEP);
      chk("R8 dma_req", dma_req, (mode == 3'b010) && q.size() != DEP);
      chk("R3 overflow", overflow, m_ovf);
      chk("R9 done", xfer_done, (q.size() == 0) && !busy_in);
    end
  end

  task automatic dma_word(input logic [PW-1:0] w);
    @(negedge clk);
    while (!dma_req) @(negedge clk);
    #1 wr_en = 1; wr_data = w;
    @(negedge clk);
    #1 wr_en = 0;
  endtask

  task automatic raw_word(input logic [PW-1:0] w);
    @(negedge clk);
    #1 wr_en = 1; wr_data = w;
    @(negedge clk);
    #1 wr_en = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (n < 4) begin
      @(negedge clk);
      if (xfer_done && pio_nstrobe) n++; else n = 0;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] exp_b[$];
    int f0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 nstrobe", pio_nstrobe, 1);
    chk("R11 data", pio_data, 0);
    chk("R11 empty", fifo_empty, 1);
    chk("R11 overflow", overflow, 0);
    #1 rst_n = 1;

    // R1 writes ignored outside FIFO mode
    raw_word(16'hBEEF);
    raw_word(16'hCAFE);
    repeat (3) @(negedge clk);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 nstrobe", pio_nstrobe, 1);
    chk("R1 dma_req", dma_req, 0);

    // R4 byte order, low byte first
    #1 mode = 3'b010; got.delete();
    dma_word(16'h2211); exp_b.push_back(8'h11); exp_b.push_back(8'h22);
    dma_word(16'h4433); exp_b.push_back(8'h33); exp_b.push_back(8'h44);
    dma_word(16'h6655); exp_b.push_back(8'h55); exp_b.push_back(8'h66);
    wait_done();
    chk("R4 count", got.size(), exp_b.size());
    foreach (exp_b[k]) chk("R4 byte", (k < got.size()) ? int'(got[k]) : -1, exp_b[k]);

    // R6 short strobes, zero read as one
    #1 strobe_len = 0; hold = 0;
    dma_word(16'h7788);
    wait_done();
    #1 strobe_len = 1; hold = 5;
    dma_word(16'h99AA);
    wait_done();
    #1 strobe_len = 4;

    // R3 and R7: Busy held high, FIFO fills, extra write dropped
    #1 stuck = 1;
    repeat (2) @(negedge clk);
    f0 = nfalls;
    for (int k = 0; k < DEP + 1; k++) raw_word(16'h1000 + 16'(k));
    repeat (5) @(negedge clk);
    chk("R3 full", fifo_full, 1);
    chk("R3 overflow", overflow, 1);
    chk("R8 no request when full", dma_req, 0);
    chk("R7 no strobe while busy", nfalls, f0);

    // R10 leave mode during a live strobe
    #1 stuck = 0;
    @(negedge clk);
    while (pio_nstrobe) @(negedge clk);
    #1 mode = 3'b000;
    @(negedge clk);
    @(negedge clk);
    chk("R10 nstrobe", pio_nstrobe, 1);
    chk("R10 empty", fifo_empty, 1);
    #1 mode = 3'b010;
    f0 = nfalls;
    repeat (20) @(negedge clk);
    chk("R10 nothing left to send", nfalls, f0);
    chk("R3 sticky", overflow, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule